// File: doc/BRIEF.md
# Debounced Input Channel with Change Capture

This block forms the receive half of one general-purpose digital I/O channel. The raw pin level is inverted, so a pin pulled to ground reads as logic one and an idle pin held high by its pullup reads as logic zero. The inverted level then passes through a two-stage synchroniser. A debounce filter examines it only on a slow sample tick, nominally one pulse per millisecond. The filter adopts a new level only after that level has been seen on a programmable number of consecutive ticks.

The filter publishes the debounced level. In the clock cycle after an accepted transition it raises a one-cycle change strobe. A capture stage turns that strobe into a sticky event flag when capture is enabled. When notification is also enabled, the capture stage additionally issues a one-cycle notify request. Software or a neighbouring block clears the flag through a clear input.

The debounce filter is a two-state machine:
- **FLT_STABLE**: the sample agrees with the published level and the run counter is zero.
- **FLT_QUALIFY**: a run of disagreeing samples is being counted.

Its transitions are:
- **start**: STABLE to QUALIFY, on a disagreeing tick whose count is still short of the interval.
- **accept**: the level flips and the machine returns to STABLE, when the count reaches the interval.
- **bounce**: QUALIFY to STABLE with the counter cleared, when a tick agrees with the published level.
- **extend**: QUALIFY stays in QUALIFY and the counter advances, on a disagreeing tick that is still short of the interval.

Top module: `dio_debounce_capture`

## Requirements
- R1: The input sense is inverted. A raw pin at 0 eventually yields `level_o` = 1, and a raw pin at 1 yields `level_o` = 0.
- R2: The raw pin passes two register stages before the filter sees it. A tick in either of the first two clock cycles after a pin change still samples the old value.
- R3: The filter samples only on cycles with `tick` high. Without ticks, `level_o` never changes, however the pin moves.
- R4: `level_o` flips on the Nth consecutive tick whose sample differs from it, where N is the effective interval. It is updated at the clock edge of that tick.
- R5: A tick whose sample agrees with `level_o` during qualification restarts the count from zero.
- R6: The interval register resets to 10 ticks. It loads `cfg_ticks` on any cycle with `cfg_load` high, and the new value applies from the next cycle.
- R7: An interval value of 0 behaves as an interval of 1 tick.
- R8: In the cycle after an accepted flip, `event_o` becomes 1 if `cap_en` is high in that cycle. If `cap_en` is low, the flip is not recorded.
- R9: `notify_o` pulses high for exactly one cycle, in the same cycle `event_o` is set by a flip. It does so only when both `cap_en` and `ntf_en` are high.
- R10: `event_o` stays 1 until a cycle with `flag_clr` high and no new capture. A clear coinciding with a capture leaves it set.
- R11: After reset, `level_o`, `event_o` and `notify_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Raw pin level (active low) |
| tick | input | 1 | One-cycle sample strobe (nominally 1 kHz) |
| cfg_load | input | 1 | Load strobe for the interval register |
| cfg_ticks | input | CNT_W | Debounce interval in ticks (0 means 1) |
| cap_en | input | 1 | Change capture enable |
| ntf_en | input | 1 | Notification request enable |
| flag_clr | input | 1 | Clear of the sticky event flag |
| level_o | output | 1 | Debounced, inverted input level |
| event_o | output | 1 | Sticky change-event flag |
| notify_o | output | 1 | One-cycle notification request |

## Verification
A wrong filter state or a corrupted run counter shows up at `level_o` as a flip one or more ticks too early or too late. A flip can also be missed altogether after a bounce. Either fault is visible at the clock edge of the tick where the correct flip should or should not occur. A broken capture stage shows in the following cycle, as an `event_o` that fails to set, drops without a clear, or survives a clear, or as a `notify_o` pulse that is missing, doubled, or appears while disabled. The scoreboard compares all three outputs every cycle, so any such divergence is reported within one clock of its cause.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    // Debounce filter states
    typedef enum logic [0:0] {
        FLT_STABLE  = 1'b0,
        FLT_QUALIFY = 1'b1
    } flt_state_e;

endpackage

// File: rtl/dbc_sync.sv
module dbc_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[gi] <= RST_VAL;
                    else        stg[gi] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[gi] <= RST_VAL;
                    else        stg[gi] <= stg[gi-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dbc_interval.sv
module dbc_interval #(
    parameter int CNT_W     = 8,
    parameter int RST_TICKS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [CNT_W-1:0] cfg_ticks,
    output logic [CNT_W-1:0] eff_ticks
);
    localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RST_TICKS);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] ivl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ivl_q <= RST_VAL;
        else if (cfg_load) ivl_q <= cfg_ticks;
    end

    // A zero setting is clamped to the shortest legal interval
    always_comb begin
        if (ivl_q == '0) eff_ticks = ONE;
        else             eff_ticks = ivl_q;
    end
endmodule

// File: rtl/dbc_filter.sv
module dbc_filter
    import dbc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sample,
    input  logic [CNT_W-1:0] limit,
    output logic             level,
    output logic             chg
);
    localparam int SUM_W = CNT_W + 1;

    flt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             level_q, level_d;
    logic             chg_q, chg_d;

    logic             differ;
    logic [SUM_W-1:0] bumped;
    logic             reached;

    assign differ  = (sample != level_q);
    assign bumped  = SUM_W'(cnt_q) + SUM_W'(1);
    assign reached = (bumped >= SUM_W'(limit));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STABLE;
            cnt_q   <= '0;
            level_q <= 1'b0;
            chg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            level_q <= level_d;
            chg_q   <= chg_d;
        end
    end

    // Next-state and output decisions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        level_d = level_q;
        chg_d   = 1'b0;
        unique case (state_q)
            FLT_STABLE: begin
                if (tick && differ) begin
                    if (reached) begin              // accept
                        level_d = ~level_q;
                        chg_d   = 1'b1;
                        cnt_d   = '0;
                    end else begin                  // start
                        state_d = FLT_QUALIFY;
                        cnt_d   = bumped[CNT_W-1:0];
                    end
                end
            end
            FLT_QUALIFY: begin
                if (tick) begin
                    if (!differ) begin              // bounce
                        state_d = FLT_STABLE;
                        cnt_d   = '0;
                    end else if (reached) begin     // accept
                        state_d = FLT_STABLE;
                        level_d = ~level_q;
                        chg_d   = 1'b1;
                        cnt_d   = '0;
                    end else begin                  // extend
                        cnt_d   = bumped[CNT_W-1:0];
                    end
                end
            end
            default: begin
                state_d = FLT_STABLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign level = level_q;
    assign chg   = chg_q;
endmodule

// File: rtl/dbc_capture.sv
module dbc_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic chg,
    input  logic cap_en,
    input  logic ntf_en,
    input  logic flag_clr,
    output logic event_o,
    output logic notify_o
);
    logic hit;
    logic evt_q;
    logic ntf_q;

    assign hit = chg & cap_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
            ntf_q <= 1'b0;
        end else begin
            // a new capture wins over a simultaneous clear
            if (hit)           evt_q <= 1'b1;
            else if (flag_clr) evt_q <= 1'b0;
            ntf_q <= hit & ntf_en;
        end
    end

    assign event_o  = evt_q;
    assign notify_o = ntf_q;
endmodule

// File: rtl/dio_debounce_capture.sv
module dio_debounce_capture #(
    parameter int CNT_W      = 8,
    parameter int RST_TICKS  = 10,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_raw,
    input  logic             tick,
    input  logic             cfg_load,
    input  logic [CNT_W-1:0] cfg_ticks,
    input  logic             cap_en,
    input  logic             ntf_en,
    input  logic             flag_clr,
    output logic             level_o,
    output logic             event_o,
    output logic             notify_o
);
    logic             pin_inv;
    logic             samp;
    logic [CNT_W-1:0] eff_ticks;
    logic             chg;

    // active-low pin: ground reads as one
    assign pin_inv = ~pin_raw;

    dbc_sync #(
        .STAGES (SYNC_DEPTH),
        .RST_VAL(1'b0)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_inv),
        .q    (samp)
    );

    dbc_interval #(
        .CNT_W    (CNT_W),
        .RST_TICKS(RST_TICKS)
    ) u_ivl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_ticks(cfg_ticks),
        .eff_ticks(eff_ticks)
    );

    dbc_filter #(
        .CNT_W(CNT_W)
    ) u_flt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .sample(samp),
        .limit (eff_ticks),
        .level (level_o),
        .chg   (chg)
    );

    dbc_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .chg     (chg),
        .cap_en  (cap_en),
        .ntf_en  (ntf_en),
        .flag_clr(flag_clr),
        .event_o (event_o),
        .notify_o(notify_o)
    );
endmodule

// File: rtl/dbc_checker.sv
module dbc_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic cap_en,
    input logic ntf_en,
    input logic flag_clr,
    input logic level_o,
    input logic event_o,
    input logic notify_o
);
    // R3: the level moves only at the edge of a tick cycle
    a_r3_level_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_o) |-> $past(tick));

    // R8: a rising flag needs capture enabled in the previous cycle
    a_r8_flag_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(event_o) |-> $past(cap_en));

    // R9: a notification accompanies a set flag with both enables
    a_r9_notify_gated: assert property (@(posedge clk) disable iff (!rst_n)
        notify_o |-> (event_o && $past(cap_en) && $past(ntf_en)));

    // R9: notify only together with a level change one cycle earlier
    a_r9_notify_after_flip: assert property (@(posedge clk) disable iff (!rst_n)
        notify_o |-> !$stable($past(level_o)));

    // R10: the flag holds unless a clear is presented
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && !flag_clr) |=> event_o);
endmodule

bind dio_debounce_capture dbc_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cap_en  (cap_en),
    .ntf_en  (ntf_en),
    .flag_clr(flag_clr),
    .level_o (level_o),
    .event_o (event_o),
    .notify_o(notify_o)
);

// File: tb/tb_dio_debounce_capture.sv
module tb_dio_debounce_capture;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int WATCHDOG   = 200000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             pin_raw;
    logic             tick;
    logic             cfg_load;
    logic [CNT_W-1:0] cfg_ticks;
    logic             cap_en;
    logic             ntf_en;
    logic             flag_clr;
    logic             level_o;
    logic             event_o;
    logic             notify_o;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    string phase    = "R11";

    typedef struct {
        logic  lvl;
        logic  evt;
        logic  ntf;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference state, derived from the requirements
    logic             m_s1, m_s2, m_lvl, m_evt, m_ntf, m_chg;
    int               m_cnt;
    logic [CNT_W-1:0] m_ivl;

    always #(CLK_PERIOD/2) clk = ~clk;

    dio_debounce_capture #(.CNT_W(CNT_W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_raw),
        .tick     (tick),
        .cfg_load (cfg_load),
        .cfg_ticks(cfg_ticks),
        .cap_en   (cap_en),
        .ntf_en   (ntf_en),
        .flag_clr (flag_clr),
        .level_o  (level_o),
        .event_o  (event_o),
        .notify_o (notify_o)
    );

    task automatic chk(input logic act, input logic expv, input string what);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, expv);
        end
    endtask

    // One clock cycle of the reference model (all updates from old values)
    task automatic model_step();
        int   eff;
        logic n_s1, n_s2, n_lvl, n_evt, n_ntf, n_chg;
        int   n_cnt;
        eff   = (m_ivl == 0) ? 1 : int'(m_ivl);
        n_s1  = ~pin_raw;
        n_s2  = m_s1;
        n_lvl = m_lvl;
        n_cnt = m_cnt;
        n_chg = 1'b0;
        if (tick) begin
            if (m_s2 != m_lvl) begin
                n_cnt = m_cnt + 1;
                if (n_cnt >= eff) begin
                    n_lvl = ~m_lvl;
                    n_cnt = 0;
                    n_chg = 1'b1;
                end
            end else begin
                n_cnt = 0;
            end
        end
        n_evt = (m_chg && cap_en) ? 1'b1 : (flag_clr ? 1'b0 : m_evt);
        n_ntf = m_chg && cap_en && ntf_en;
        if (cfg_load) m_ivl = cfg_ticks;
        m_s1 = n_s1; m_s2 = n_s2; m_lvl = n_lvl; m_cnt = n_cnt;
        m_chg = n_chg; m_evt = n_evt; m_ntf = n_ntf;
    endtask

    // Driver: called at a falling edge, runs one cycle
    task automatic cyc(input logic tk);
        exp_t it;
        tick = tk;
        model_step();
        it.lvl = m_lvl; it.evt = m_evt; it.ntf = m_ntf; it.tag = phase;
        exp_q.push_back(it);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    task automatic settle();
        for (int i = 0; i < 3; i++) cyc(1'b0);
    endtask

    task automatic load_ivl(input int v);
        cfg_ticks = CNT_W'(v);
        cfg_load  = 1'b1;
        cyc(1'b0);
        cfg_load  = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        cyc(1'b0);
        flag_clr = 1'b0;
    endtask

    // Monitor: compares every cycle shortly after the rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            chk(level_o,  it.lvl, {it.tag, " level_o"});
            chk(event_o,  it.evt, {it.tag, " event_o"});
            chk(notify_o, it.ntf, {it.tag, " notify_o"});
        end
    end

    initial begin
        rst_n = 1'b0; pin_raw = 1'b1; tick = 1'b0; cfg_load = 1'b0;
        cfg_ticks = '0; cap_en = 1'b0; ntf_en = 1'b0; flag_clr = 1'b0;
        m_s1 = 0; m_s2 = 0; m_lvl = 0; m_evt = 0; m_ntf = 0; m_chg = 0;
        m_cnt = 0; m_ivl = CNT_W'(10);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset values
        chk(level_o, 1'b0, "R11 level_o after reset");
        chk(event_o, 1'b0, "R11 event_o after reset");
        chk(notify_o, 1'b0, "R11 notify_o after reset");

        // R6 default interval 10, R1 inverted sense, R4 timing
        phase = "R6"; pin_raw = 1'b0; settle();
        ticks(9);
        chk(level_o, 1'b0, "R6 no flip after 9 ticks");
        phase = "R4"; ticks(1);
        chk(level_o, 1'b1, "R1 low pin reads one on tick 10");
        cyc(1'b0);
        chk(event_o, 1'b0, "R8 no capture while disabled");

        // R9 capture and notify
        phase = "R9"; cap_en = 1'b1; ntf_en = 1'b1; pin_raw = 1'b1; settle();
        ticks(10);
        chk(level_o, 1'b0, "R1 high pin reads zero");
        cyc(1'b0);
        chk(event_o, 1'b1, "R8 flag set on change");
        chk(notify_o, 1'b1, "R9 notify pulse");
        cyc(1'b0);
        chk(notify_o, 1'b0, "R9 notify lasts one cycle");
        chk(event_o, 1'b1, "R10 flag sticky");
        phase = "R10"; clear_flag();
        chk(event_o, 1'b0, "R10 flag cleared");

        // R5 bounce restarts with interval 4
        phase = "R5"; load_ivl(4);
        pin_raw = 1'b0; settle(); ticks(3);
        pin_raw = 1'b1; settle(); ticks(1);
        pin_raw = 1'b0; settle(); ticks(3);
        chk(level_o, 1'b0, "R5 count restarted after bounce");
        ticks(1);
        chk(level_o, 1'b1, "R5 flip after 4 clean ticks");
        cyc(1'b0);
        clear_flag();

        // R10 clear coinciding with capture
        phase = "R10"; pin_raw = 1'b1; settle(); ticks(4);
        clear_flag();
        chk(event_o, 1'b1, "R10 capture beats clear");

        // R8 capture disabled, R9 notify disabled
        phase = "R8"; cap_en = 1'b0; clear_flag();
        pin_raw = 1'b0; settle(); ticks(4); cyc(1'b0);
        chk(event_o, 1'b0, "R8 capture disabled");
        chk(notify_o, 1'b0, "R9 no notify without capture");
        phase = "R9"; cap_en = 1'b1; ntf_en = 1'b0;
        pin_raw = 1'b1; settle(); ticks(4); cyc(1'b0);
        chk(event_o, 1'b1, "R8 captured with notify off");
        chk(notify_o, 1'b0, "R9 notify disabled");

        // R7 zero interval acts as one tick
        phase = "R7"; load_ivl(0);
        pin_raw = 1'b0; settle(); ticks(1);
        chk(level_o, 1'b1, "R7 zero interval flips on one tick");

        // R3 no ticks, no change
        phase = "R3"; pin_raw = 1'b1;
        for (int i = 0; i < 20; i++) cyc(1'b0);
        chk(level_o, 1'b1, "R3 held without ticks");
        ticks(1);
        chk(level_o, 1'b0, "R3 flips on first tick");

        // R2 synchroniser depth
        phase = "R2"; pin_raw = 1'b0; ticks(2);
        chk(level_o, 1'b0, "R2 early ticks see old value");
        ticks(1);
        chk(level_o, 1'b1, "R2 third tick sees new value");
        settle();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule